// File: doc/BRIEF.md
# Dual-Channel Byte-Loaded Converter Register Front End

This block sits in front of a two-channel 12-bit digital-to-analog converter and collects the code for each channel over a narrow 8-bit host port. The 12-bit code for a channel arrives in two bus writes. One write carries the lower eight bits. The other carries the upper four bits. The two address bits pick which of the four staging registers is written. A single latch strobe then moves both staged words into the two converter registers in the same clock cycle, so both channels change together.

The host strobes are asynchronous to the system clock. Each one passes through a synchronizer, and the clocked registers imitate level-transparent latches. While a strobe is held low with chip select low, the target register follows the port. When the strobe rises, the register keeps its value. Clear, which is active low, wipes the staging registers. It also loads the converter registers with a zero code chosen by the mode pin: unipolar zero or bipolar mid-scale. System reset acts as a clear taken with the current mode value.

Top module: `dac_port_regs`

## Requirements
- R1: Address `a_i` selects the staging register: 0 = channel A bits 7..0, 1 = channel A bits 11..8, 2 = channel B bits 7..0, 3 = channel B bits 11..8.
- R2: A write to a low-byte address places `d_i[7:0]` in bits 7..0 of that channel's staged word.
- R3: A write to a high-nibble address places `d_i[3:0]` in bits 11..8 of the staged word, and `d_i[7:4]` has no effect.
- R4: While `cs_n_i` and `wr_n_i` are both low, the addressed staging register tracks the port. After `wr_n_i` rises, the register keeps the last value.
- R5: Staged words reach `out_a_o`/`out_b_o` only while `cs_n_i` and `le_n_i` are both low. Both channels are updated in the same cycle.
- R6: With `wr_n_i`, `le_n_i` and `cs_n_i` all low, the port value passes straight through to the output of the addressed channel.
- R7: With `cs_n_i` high, or with both `wr_n_i` and `le_n_i` high, no register changes.
- R8: While `clr_n_i` is low, both staged words are 12'h000 and writes are ignored.
- R9: While `clr_n_i` is low, both outputs equal 12'h000 if `mode_i` is 0, and 12'h800 if `mode_i` is 1.
- R10: After reset, both outputs hold the clear value set by `mode_i`.
- R11: A latch strobe shows at the outputs on the third rising clock edge after it is applied, and not before.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset, treated as a clear |
| d_i | input | 8 | Host data port |
| a_i | input | 2 | Staging register select |
| cs_n_i | input | 1 | Active-low chip select |
| wr_n_i | input | 1 | Active-low write strobe |
| le_n_i | input | 1 | Active-low latch strobe, both channels |
| clr_n_i | input | 1 | Active-low asynchronous clear |
| mode_i | input | 1 | Clear code select: 0 unipolar zero, 1 bipolar zero |
| out_a_o | output | 12 | Channel A converter register |
| out_b_o | output | 12 | Channel B converter register |

## Verification
The assertions assume that every host input stays stable for at least two clock periods around each strobe edge. Under that assumption, address, data and strobes reach the register logic in the same synchronized cycle and no partially synchronized write can appear. The assertions also assume that the mode pin is settled before clear is asserted. The stimulus meets both conditions. Address and data are set one clock before a strobe falls and held until after it rises. Strobes are held low for four clocks. Mode is changed only while clear is high, and the bench then waits before asserting clear.

// File: rtl/dac_port_regs.sv
module dac_port_regs #(
  parameter int HI_W        = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [7:0]         d_i,
  input  logic [1:0]         a_i,
  input  logic               cs_n_i,
  input  logic               wr_n_i,
  input  logic               le_n_i,
  input  logic               clr_n_i,
  input  logic               mode_i,
  output logic [8+HI_W-1:0]  out_a_o,
  output logic [8+HI_W-1:0]  out_b_o
);
  localparam int W     = 8 + HI_W;
  localparam int BUS_W = 8 + 2 + 4;
  localparam logic [W-1:0] BIP_ZERO = W'(1) << (W-1);

  logic [BUS_W-1:0] sh [SYNC_STAGES];
  logic [SYNC_STAGES-1:0] clr_sh;
  logic clr_raw_n, clr_q;

  assign clr_raw_n = rst_n & clr_n_i;

  always_ff @(posedge clk) begin
    sh[0] <= {mode_i, le_n_i, wr_n_i, cs_n_i, a_i, d_i};
    for (int i = 1; i < SYNC_STAGES; i++) sh[i] <= sh[i-1];
  end

  always_ff @(posedge clk or negedge clr_raw_n)
    if (!clr_raw_n) clr_sh <= '0;
    else            clr_sh <= {clr_sh[SYNC_STAGES-2:0], 1'b1};
  assign clr_q = clr_sh[SYNC_STAGES-1];

  logic [7:0] d_s;
  logic [1:0] a_s;
  logic cs_s, wr_s, le_s, mode_s, wr_act, le_act;
  assign {mode_s, le_s, wr_s, cs_s, a_s, d_s} = sh[SYNC_STAGES-1];
  assign wr_act = !cs_s && !wr_s;
  assign le_act = !cs_s && !le_s;

  logic [W-1:0] in_a, in_b, nx_a, nx_b;

  always_comb begin
    nx_a = in_a;
    nx_b = in_b;
    if (wr_act)
      case (a_s)
        2'd0: nx_a[7:0]   = d_s;
        2'd1: nx_a[W-1:8] = d_s[HI_W-1:0];
        2'd2: nx_b[7:0]   = d_s;
        default: nx_b[W-1:8] = d_s[HI_W-1:0];
      endcase
  end

  always_ff @(posedge clk or negedge clr_q)
    if (!clr_q) begin
      in_a <= '0;
      in_b <= '0;
    end else begin
      in_a <= nx_a;
      in_b <= nx_b;
    end

  always_ff @(posedge clk)
    if (!clr_q) begin
      out_a_o <= mode_s ? BIP_ZERO : '0;
      out_b_o <= mode_s ? BIP_ZERO : '0;
    end else if (le_act) begin
      out_a_o <= nx_a;
      out_b_o <= nx_b;
    end

  a_r5_update_on_latch: assert property (@(posedge clk) disable iff (!rst_n)
    (out_a_o != $past(out_a_o) || out_b_o != $past(out_b_o))
      |-> ($past(le_act) || !$past(clr_q)));

  a_r7_idle_no_change: assert property (@(posedge clk) disable iff (!clr_q)
    (cs_s || (wr_s && le_s)) |=> ($stable(in_a) && $stable(in_b)
                                  && $stable(out_a_o) && $stable(out_b_o)));

  a_r8_staging_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_q |=> (!clr_q -> (in_a == '0 && in_b == '0)));

  a_r9_clear_value: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_q |=> (out_a_o == ($past(mode_s) ? BIP_ZERO : '0)) && (out_b_o == out_a_o));

  a_r4_write_only: assert property (@(posedge clk) disable iff (!rst_n)
    (in_a != $past(in_a) || in_b != $past(in_b))
      |-> ($past(wr_act) || !clr_q || !$past(clr_q)));
endmodule

// File: tb/dac_port_regs_tb_top.sv
module dac_port_regs_tb_top;
  localparam int CLK_P = 10;

  logic clk = 0, rst_n = 0;
  logic [7:0] d_i = 0;
  logic [1:0] a_i = 0;
  logic cs_n_i = 1, wr_n_i = 1, le_n_i = 1, clr_n_i = 1, mode_i = 1;
  logic [11:0] out_a_o, out_b_o;
  int checks = 0, fails = 0;

  always #(CLK_P/2) clk = ~clk;

  dac_port_regs dut_i (.clk(clk), .rst_n(rst_n), .d_i(d_i), .a_i(a_i),
    .cs_n_i(cs_n_i), .wr_n_i(wr_n_i), .le_n_i(le_n_i), .clr_n_i(clr_n_i),
    .mode_i(mode_i), .out_a_o(out_a_o), .out_b_o(out_b_o));

  task automatic cyc(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic chk(string req, logic [11:0] act, logic [11:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr_byte(logic [1:0] a, logic [7:0] d);
    a_i = a; d_i = d; cs_n_i = 0; cyc(1);
    wr_n_i = 0; cyc(4);
    wr_n_i = 1; cyc(1);
    cs_n_i = 1; cyc(2);
  endtask

  task automatic latch();
    cs_n_i = 0; cyc(1);
    le_n_i = 0; cyc(4);
    le_n_i = 1; cyc(1);
    cs_n_i = 1; cyc(2);
  endtask

  task automatic t_reset();
    mode_i = 1; rst_n = 0; cyc(5);
    rst_n = 1; cyc(4);
    chk("R10 A", out_a_o, 12'h800);
    chk("R10 B", out_b_o, 12'h800);
  endtask

  task automatic t_map();
    wr_byte(2'd0, 8'h34);
    wr_byte(2'd1, 8'hF2);
    wr_byte(2'd2, 8'hCD);
    wr_byte(2'd3, 8'h0A);
    chk("R5 held A", out_a_o, 12'h800);
    chk("R5 held B", out_b_o, 12'h800);
    latch();
    chk("R1 R2 R3 A", out_a_o, 12'h234);
    chk("R1 R2 R5 B", out_b_o, 12'hACD);
  endtask

  task automatic t_idle();
    a_i = 2'd0; d_i = 8'hFF; cs_n_i = 1; cyc(1);
    wr_n_i = 0; le_n_i = 0; cyc(4);
    wr_n_i = 1; le_n_i = 1; cyc(2);
    chk("R7 cs high out", out_a_o, 12'h234);
    cs_n_i = 0; cyc(4); cs_n_i = 1; cyc(2);
    latch();
    chk("R7 staging kept A", out_a_o, 12'h234);
    chk("R7 staging kept B", out_b_o, 12'hACD);
  endtask

  task automatic t_follow();
    a_i = 2'd0; d_i = 8'h11; cs_n_i = 0; cyc(1);
    wr_n_i = 0; cyc(3);
    d_i = 8'h22; cyc(3);
    wr_n_i = 1; cyc(2);
    d_i = 8'h99; cyc(3);
    cs_n_i = 1; cyc(2);
    latch();
    chk("R4 follow then hold", out_a_o, 12'h222);
  endtask

  task automatic t_through();
    a_i = 2'd2; d_i = 8'h55; cs_n_i = 0; cyc(1);
    wr_n_i = 0; le_n_i = 0; cyc(4);
    chk("R6 pass B", out_b_o, 12'hA55);
    d_i = 8'h66; cyc(4);
    chk("R6 pass B second", out_b_o, 12'hA66);
    chk("R6 A unchanged", out_a_o, 12'h222);
    wr_n_i = 1; le_n_i = 1; cyc(1);
    cs_n_i = 1; cyc(2);
  endtask

  task automatic t_clear(logic m, logic [11:0] exp);
    mode_i = m; cyc(4);
    clr_n_i = 0; cyc(3);
    chk("R9 A", out_a_o, exp);
    chk("R9 B", out_b_o, exp);
    a_i = 2'd0; d_i = 8'hFF; cs_n_i = 0; wr_n_i = 0; cyc(4);
    wr_n_i = 1; cs_n_i = 1; cyc(2);
    clr_n_i = 1; cyc(4);
    latch();
    chk("R8 A zero", out_a_o, 12'h000);
    chk("R8 B zero", out_b_o, 12'h000);
  endtask

  task automatic t_latency();
    wr_byte(2'd0, 8'h77);
    wr_byte(2'd1, 8'hA5);
    cs_n_i = 0; cyc(1);
    @(negedge clk); le_n_i = 0;
    cyc(2);
    chk("R11 not yet", out_a_o, 12'h000);
    cyc(1);
    chk("R11 third edge", out_a_o, 12'h577);
    le_n_i = 1; cyc(1); cs_n_i = 1; cyc(2);
  endtask

  initial begin
    t_reset();
    t_map();
    t_idle();
    t_follow();
    t_through();
    t_clear(1'b0, 12'h000);
    t_latency();
    t_clear(1'b1, 12'h800);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    #(CLK_P * 200000);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule